// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects per-source interrupt events into a 32-bit cause register and lets software see, mask and acknowledge them through seven word registers on a simple single-cycle register bus. Bit n of every register belongs to source n. A hardware event pulse on a source latches its cause bit. Software can also force cause bits through a write-only set register.

A control register picks the acknowledge style of each bit at run time. With a control bit of 0, the cause bit is cleared by writing a 1 to it. With a control bit of 1, the cause bit is cleared by reading it. Two views of the cause exist: the raw view and a masked view (cause AND NOT mask). Both views obey the chosen acknowledge style and act on the same underlying cause bits.

The mask can be written directly or changed through set and clear aliases. A registered, active-high level interrupt reports whether any unmasked cause is pending. Reads take effect on the accepting cycle and return data on the following cycle.

Top module: `irq_cause_bank`

## Requirements
- R1: A synchronous active-high reset clears the control, cause and mask registers to 0, which leaves every source unmasked; rd_data and irq_out are 0 after reset.
- R2: A read is accepted when req_valid=1 and req_write=0, and rd_data carries its value on the next cycle (0 on cycles after no read). Word offsets are 0 control, 1 cause, 2 masked cause, 3 cause-set, 4 mask, 5 mask-set, 6 mask-clear. Reads of offsets 3, 5, 6 and 7 return 0.
- R3: hw_event bit n high in a cycle makes cause bit n read 1 from the next cycle onward, until it is cleared.
- R4: For a control bit of 0, writing a 1 to that bit at offset 1 or offset 2 clears the cause bit, and writing a 0 leaves it unchanged.
- R5: For a control bit of 1, an accepted read of offset 1 returns the cause bit before the clear and then clears it. Writes to offsets 1 and 2 leave that bit unchanged.
- R6: A read of offset 2 returns cause AND NOT mask. Such a read clears only those bits that have a control bit of 1 and a mask bit of 0.
- R7: Writing offset 3 sets every cause bit whose data bit is 1.
- R8: Writing offset 4 loads the mask. Writing offset 5 ORs the data into the mask. Writing offset 6 clears the mask bits whose data bit is 1. Nothing else changes the mask.
- R9: If a hardware event and a clear hit the same cause bit in the same cycle, the bit stays set.
- R10: irq_out is the OR of cause AND NOT mask, registered, so it follows a change in the cause or mask one cycle later.
- R11: Writing offset 0 loads the control register, and a read of offset 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word offset within the bank |
| req_wdata | input | SRC_W | Write data |
| hw_event | input | SRC_W | Per-source event pulses, already synchronous |
| rd_data | output | SRC_W | Read data, valid the cycle after a read |
| irq_out | output | 1 | Level interrupt, registered |

## Verification
The bench targets the run-time choice of acknowledge style, including a bit switching from clear-by-write to clear-by-read mid-run:
- A design that ignored the control bit would clear a clear-on-read bit on a write, or leave it set after a read.
- A design that cleared before capturing would return zero on the first read of a clear-on-read bit.
- A clear-on-read through the masked view is checked so that masked bits survive. A design clearing all cause bits there would lose the masked source.

The bench also covers three more corner cases:
- An event colliding with a write-one clear: an inverted priority would drop the event.
- The mask aliases: a design that copied instead of merged would wipe other mask bits.
- The interrupt with all pending sources masked: a design that ignored the mask would drive irq_out high.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

  localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CAUSE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_MASKED = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_SET    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_MSET   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFF_MCLR   = ADDR_W'(6);
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
  import irqb_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              wr_ctrl,
  output logic              wr_cause,
  output logic              wr_masked,
  output logic              wr_set,
  output logic              wr_mask,
  output logic              wr_mset,
  output logic              wr_mclr,
  output logic              rd_en,
  output logic              rd_cause,
  output logic              rd_masked
);
  logic wr_en;

  always_comb begin
    wr_en     = req_valid && req_write;
    rd_en     = req_valid && !req_write;
    wr_ctrl   = wr_en && (req_addr == OFF_CTRL);
    wr_cause  = wr_en && (req_addr == OFF_CAUSE);
    wr_masked = wr_en && (req_addr == OFF_MASKED);
    wr_set    = wr_en && (req_addr == OFF_SET);
    wr_mask   = wr_en && (req_addr == OFF_MASK);
    wr_mset   = wr_en && (req_addr == OFF_MSET);
    wr_mclr   = wr_en && (req_addr == OFF_MCLR);
    rd_cause  = rd_en && (req_addr == OFF_CAUSE);
    rd_masked = rd_en && (req_addr == OFF_MASKED);
  end
endmodule

// File: rtl/irqb_cause_bit.sv
module irqb_cause_bit (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_cor,
  input  logic mask_bit,
  input  logic event_in,
  input  logic wdata_bit,
  input  logic wr_cause,
  input  logic wr_masked,
  input  logic wr_set,
  input  logic rd_cause,
  input  logic rd_masked,
  output logic cause_q
);
  logic hit_w1c;
  logic hit_cor;
  logic do_set;

  always_comb begin
    hit_w1c = !ctrl_cor && wdata_bit && (wr_cause || wr_masked);
    hit_cor = ctrl_cor && (rd_cause || (rd_masked && !mask_bit));
    do_set  = event_in || (wr_set && wdata_bit);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cause_q <= 1'b0;
    else if (do_set)
      cause_q <= 1'b1;
    else if (hit_w1c || hit_cor)
      cause_q <= 1'b0;
  end
endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_mask,
  input  logic         wr_mset,
  input  logic         wr_mclr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (wr_mask)
      mask_q <= wdata;
    else if (wr_mset)
      mask_q <= mask_q | wdata;
    else if (wr_mclr)
      mask_q <= mask_q & ~wdata;
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irqb_pkg::*;
#(
  parameter int unsigned SRC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_wdata,
  input  logic [SRC_W-1:0]  hw_event,
  output logic [SRC_W-1:0]  rd_data,
  output logic              irq_out
);
  logic wr_ctrl, wr_cause, wr_masked, wr_set, wr_mask, wr_mset, wr_mclr;
  logic rd_en, rd_cause, rd_masked;
  logic [SRC_W-1:0] ctrl_q;
  logic [SRC_W-1:0] cause_q;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] masked_view;
  logic [SRC_W-1:0] rd_mux;
  logic             irq_q;

  irqb_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_ctrl   (wr_ctrl),
    .wr_cause  (wr_cause),
    .wr_masked (wr_masked),
    .wr_set    (wr_set),
    .wr_mask   (wr_mask),
    .wr_mset   (wr_mset),
    .wr_mclr   (wr_mclr),
    .rd_en     (rd_en),
    .rd_cause  (rd_cause),
    .rd_masked (rd_masked)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_ctrl)
      ctrl_q <= req_wdata;
  end

  irqb_mask #(.W(SRC_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_mset (wr_mset),
    .wr_mclr (wr_mclr),
    .wdata   (req_wdata),
    .mask_q  (mask_q)
  );

  for (genvar n = 0; n < SRC_W; n++) begin : g_src
    irqb_cause_bit u_bit (
      .clk       (clk),
      .rst       (rst),
      .ctrl_cor  (ctrl_q[n]),
      .mask_bit  (mask_q[n]),
      .event_in  (hw_event[n]),
      .wdata_bit (req_wdata[n]),
      .wr_cause  (wr_cause),
      .wr_masked (wr_masked),
      .wr_set    (wr_set),
      .rd_cause  (rd_cause),
      .rd_masked (rd_masked),
      .cause_q   (cause_q[n])
    );
  end

  always_comb begin
    masked_view = cause_q & ~mask_q;
    case (req_addr)
      OFF_CTRL:   rd_mux = ctrl_q;
      OFF_CAUSE:  rd_mux = cause_q;
      OFF_MASKED: rd_mux = masked_view;
      OFF_MASK:   rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_q   <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      irq_q   <= |masked_view;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker
  import irqb_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [W-1:0]      req_wdata,
  input logic [W-1:0]      hw_event,
  input logic [W-1:0]      rd_data,
  input logic              irq_out,
  input logic [W-1:0]      cause_q,
  input logic [W-1:0]      mask_q
);
  logic set_wr, mask_wr, rd_raw, rd_msk;
  always_comb begin
    set_wr  = req_valid && req_write && (req_addr == OFF_SET);
    mask_wr = req_valid && req_write &&
              ((req_addr == OFF_MASK) || (req_addr == OFF_MSET) || (req_addr == OFF_MCLR));
    rd_raw  = req_valid && !req_write && (req_addr == OFF_CAUSE);
    rd_msk  = req_valid && !req_write && (req_addr == OFF_MASKED);
  end

  // R3 and R9: an event always lands in the cause register
  a_r3_event_latches: assert property (@(posedge clk) disable iff (rst)
    (|hw_event) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

  // R7
  a_r7_set_latches: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((cause_q & $past(req_wdata)) == $past(req_wdata)));

  // R5: read of the raw cause returns the pre-clear value
  a_r5_raw_readback: assert property (@(posedge clk) disable iff (rst)
    rd_raw |=> (rd_data == $past(cause_q)));

  // R6
  a_r6_masked_readback: assert property (@(posedge clk) disable iff (rst)
    rd_msk |=> (rd_data == $past(cause_q & ~mask_q)));

  // R8: only mask writes move the mask
  a_r8_mask_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q));

  // R10
  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_out == $past(|(cause_q & ~mask_q))));
endmodule

bind irq_cause_bank irqb_checker #(.W(SRC_W)) u_irqb_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .hw_event  (hw_event),
  .rd_data   (rd_data),
  .irq_out   (irq_out),
  .cause_q   (cause_q),
  .mask_q    (mask_q)
);

// File: tb/test_irq_cause_bank.sv
`timescale 1ns/1ps
module test_irq_cause_bank;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [2:0]   req_addr  = '0;
  logic [W-1:0] req_wdata = '0;
  logic [W-1:0] hw_event  = '0;
  logic [W-1:0] rd_data;
  logic         irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_cause_bank #(.SRC_W(W)) i_irq_cause_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .hw_event(hw_event),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  // behavioural reference
  logic [W-1:0] m_ctrl, m_cause, m_mask, exp_rd;
  logic         exp_irq;
  always @(posedge clk) begin
    logic [W-1:0] rv, clr, st, nmask, nctrl;
    if (rst) begin
      m_ctrl = '0; m_cause = '0; m_mask = '0; exp_rd = '0; exp_irq = 1'b0;
    end else begin
      rv = '0; clr = '0; st = hw_event; nmask = m_mask; nctrl = m_ctrl;
      exp_irq = (m_cause & ~m_mask) != 0;
      if (req_valid && !req_write) begin
        if (req_addr == 0) rv = m_ctrl;
        else if (req_addr == 1) begin rv = m_cause; clr = m_ctrl; end
        else if (req_addr == 2) begin rv = m_cause & ~m_mask; clr = m_ctrl & ~m_mask; end
        else if (req_addr == 4) rv = m_mask;
      end
      if (req_valid && req_write) begin
        if (req_addr == 0) nctrl = req_wdata;
        else if (req_addr == 1 || req_addr == 2) clr = req_wdata & ~m_ctrl;
        else if (req_addr == 3) st = st | req_wdata;
        else if (req_addr == 4) nmask = req_wdata;
        else if (req_addr == 5) nmask = m_mask | req_wdata;
        else if (req_addr == 6) nmask = m_mask & ~req_wdata;
      end
      exp_rd  = rv;
      m_cause = (m_cause & ~clr) | st;
      m_mask  = nmask;
      m_ctrl  = nctrl;
    end
  end

  // per-cycle comparison (R2 read data, R10 interrupt)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL R2 cycle rd_data actual=%h expected=%h", rd_data, exp_rd);
      end
      checks++;
      if (irq_out !== exp_irq) begin
        errors++;
        $display("FAIL R10 cycle irq_out actual=%b expected=%b", irq_out, exp_irq);
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = '0;
  endtask

  task automatic write_with_event(input logic [2:0] a, input logic [W-1:0] d,
                                  input logic [W-1:0] ev);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; hw_event = ev;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = '0; hw_event = '0;
  endtask

  task automatic pulse_event(input logic [W-1:0] ev);
    @(negedge clk);
    hw_event = ev;
    @(negedge clk);
    hw_event = '0;
  endtask

  task automatic read_check(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s offset %0d actual=%h expected=%h", tag, a, rd_data, e);
    end
  endtask

  task automatic irq_check(input logic e, input string tag);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, e);
    end
  endtask

  task automatic report;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    read_check(3'd0, 32'h0, "R1");
    read_check(3'd1, 32'h0, "R1");
    read_check(3'd2, 32'h0, "R1");
    read_check(3'd4, 32'h0, "R1");
    irq_check(1'b0, "R1");
    // R3 event latch, R10 interrupt rises
    pulse_event(32'h8);
    read_check(3'd1, 32'h8, "R3");
    irq_check(1'b1, "R10");
    // R4 write-one-to-clear
    bus_write(3'd1, 32'h1);
    read_check(3'd1, 32'h8, "R4");
    bus_write(3'd1, 32'h8);
    read_check(3'd1, 32'h0, "R4");
    // R11 control, R5 clear-on-read
    bus_write(3'd0, 32'h30);
    read_check(3'd0, 32'h30, "R11");
    pulse_event(32'h10);
    read_check(3'd1, 32'h10, "R5");
    read_check(3'd1, 32'h0, "R5");
    pulse_event(32'h20);
    bus_write(3'd1, 32'h20);
    read_check(3'd1, 32'h20, "R5");
    read_check(3'd1, 32'h0, "R5");
    // R7 set, R6 masked view
    bus_write(3'd4, 32'h1);
    bus_write(3'd3, 32'h3);
    read_check(3'd2, 32'h2, "R6");
    read_check(3'd1, 32'h3, "R7");
    // R2 write-only / alias / unused reads
    read_check(3'd3, 32'h0, "R2");
    read_check(3'd5, 32'h0, "R2");
    read_check(3'd6, 32'h0, "R2");
    read_check(3'd7, 32'h0, "R2");
    // R8 mask aliases
    bus_write(3'd5, 32'hF0);
    read_check(3'd4, 32'hF1, "R8");
    bus_write(3'd6, 32'h11);
    read_check(3'd4, 32'hE0, "R8");
    // R6 clear-on-read through masked view spares masked bits
    bus_write(3'd0, 32'h3);
    bus_write(3'd4, 32'h1);
    read_check(3'd2, 32'h2, "R6");
    read_check(3'd1, 32'h1, "R6");
    read_check(3'd1, 32'h0, "R6");
    // R9 event beats a clear in the same cycle
    bus_write(3'd0, 32'h0);
    bus_write(3'd3, 32'h40);
    write_with_event(3'd1, 32'h40, 32'h40);
    read_check(3'd1, 32'h40, "R9");
    bus_write(3'd1, 32'h40);
    read_check(3'd1, 32'h0, "R9");
    // R10 interrupt with mask
    bus_write(3'd3, 32'h4);
    irq_check(1'b1, "R10");
    bus_write(3'd5, 32'h4);
    irq_check(1'b0, "R10");
    bus_write(3'd6, 32'h4);
    irq_check(1'b1, "R10");
    repeat (4) @(negedge clk);
    report();
  end
endmodule